// File: doc/BRIEF.md
# PS/2 Keyboard ASCII Read Port

This block listens to a PS/2 keyboard's clock and data lines, assembles the serial frames it sends, and turns key presses into 7-bit ASCII. The result sits in one byte-wide register that a processor reads through a chip select and a read strobe. The register cannot be written.

Bit 7 of the port is a new-key flag. A key press sets it. The first selected read returns it as 1, and the end of that read clears it. Bits 6 to 0 keep the ASCII code of the most recent key. Polling software therefore tests bit 7 to find out whether a key is waiting, and masks it off to get the character. Pressing the A key gives 0xC1 on the first read and 0x41 on every read after that.

The decoder covers letters (always upper case), digits, space and enter. Either shift key selects the symbol printed above each digit key. Release sequences and extended-key sequences never produce a key. A frame with a bad parity bit or a bad stop bit is dropped.

Top module: `kbd_ascii_port`

## Requirements
- R1: A frame is a 0 start bit, eight data bits sent least significant bit first, an odd parity bit and a 1 stop bit. Each bit is sampled on a falling edge of the filtered keyboard clock.
- R2: A frame whose parity is even, or whose stop bit reads 0, is dropped and leaves the port unchanged.
- R3: After reset the port reads 0x00. An accepted key sets bit 7 and loads its ASCII code into bits 6..0.
- R4: The flag clears at the end of a selected read (cs_i and rd_i both high), so the read after it returns bit 7 = 0 with the same code. A key accepted in the cycle where the flag would clear leaves the flag set.
- R5: Asserting rd_i while cs_i is low has no effect on the flag.
- R6: Letters map to upper-case ASCII (A..Z = 0x41..0x5A), digits map to 0x30..0x39, space (0x29) maps to 0x20 and enter (0x5A) maps to 0x0D.
- R7: Code 0xF0 marks the next code as a release. That release produces no key and leaves the port unchanged.
- R8: Code 0xE0 marks the next code as extended. That code is skipped and produces no key.
- R9: While left shift (0x12) or right shift (0x59) is held, the digit keys give their shifted symbols (for example 1 gives 0x21 and 2 gives 0x40) and letters stay upper case. Releasing the shift key (0xF0 followed by its code) restores the unshifted digits.
- R10: A scan code with no mapping, such as 0x05, produces no key.
- R11: If the keyboard clock stays high for TIMEOUT_CYC cycles while a frame is in progress, the receiver drops that frame and waits for a new start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_i | input | 1 | Keyboard clock line, asynchronous to clk |
| ps2_dat_i | input | 1 | Keyboard data line, asynchronous to clk |
| cs_i | input | 1 | Port chip select |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Bit 7 is the new-key flag; bits 6..0 are the ASCII code |

## Verification
After the stop-bit falling edge, a key reaches rdata_o through the following registers:
- the synchroniser,
- the glitch filter's dwell count,
- edge detection,
- the frame register,
- the decoder register,
- the latch.

That path is at most about a dozen clock cycles. The bench therefore waits a fixed settle time that is well beyond this path after every frame before it reads the port.

Reads are timed as follows:
- Each read holds cs_i and rd_i for one cycle.
- The bench samples rdata_o at the falling clock edge inside that cycle, before the flag clears.
- The flag clears at the next rising edge, so the next sample shows the cleared value.

Discard cases (bad frames, releases, extended codes, unmapped codes and the ignored read) are checked by reading the port after the same settle time and confirming that the flag and the code have not changed.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;

    localparam logic [7:0] SC_RELEASE = 8'hF0;
    localparam logic [7:0] SC_EXTEND  = 8'hE0;
    localparam logic [7:0] SC_LSHIFT  = 8'h12;
    localparam logic [7:0] SC_RSHIFT  = 8'h59;

    typedef struct packed {
        logic       hit;
        logic [6:0] code;
    } ascii_lookup_t;

    typedef struct packed {
        logic release_pend;
        logic ext_pend;
        logic shift_l;
        logic shift_r;
    } dec_state_t;

    function automatic ascii_lookup_t scan_lookup(input logic [7:0] sc, input logic shifted);
        ascii_lookup_t r;
        r.hit  = 1'b1;
        r.code = 7'h00;
        case (sc)
            8'h1C: r.code = 7'h41; 8'h32: r.code = 7'h42; 8'h21: r.code = 7'h43;
            8'h23: r.code = 7'h44; 8'h24: r.code = 7'h45; 8'h2B: r.code = 7'h46;
            8'h34: r.code = 7'h47; 8'h33: r.code = 7'h48; 8'h43: r.code = 7'h49;
            8'h3B: r.code = 7'h4A; 8'h42: r.code = 7'h4B; 8'h4B: r.code = 7'h4C;
            8'h3A: r.code = 7'h4D; 8'h31: r.code = 7'h4E; 8'h44: r.code = 7'h4F;
            8'h4D: r.code = 7'h50; 8'h15: r.code = 7'h51; 8'h2D: r.code = 7'h52;
            8'h1B: r.code = 7'h53; 8'h2C: r.code = 7'h54; 8'h3C: r.code = 7'h55;
            8'h2A: r.code = 7'h56; 8'h1D: r.code = 7'h57; 8'h22: r.code = 7'h58;
            8'h35: r.code = 7'h59; 8'h1A: r.code = 7'h5A;
            8'h16: r.code = shifted ? 7'h21 : 7'h31;
            8'h1E: r.code = shifted ? 7'h40 : 7'h32;
            8'h26: r.code = shifted ? 7'h23 : 7'h33;
            8'h25: r.code = shifted ? 7'h24 : 7'h34;
            8'h2E: r.code = shifted ? 7'h25 : 7'h35;
            8'h36: r.code = shifted ? 7'h5E : 7'h36;
            8'h3D: r.code = shifted ? 7'h26 : 7'h37;
            8'h3E: r.code = shifted ? 7'h2A : 7'h38;
            8'h46: r.code = shifted ? 7'h28 : 7'h39;
            8'h45: r.code = shifted ? 7'h29 : 7'h30;
            8'h29: r.code = 7'h20;
            8'h5A: r.code = 7'h0D;
            default: r.hit = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILTER_LEN  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(FILTER_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   clean_q;
    logic                   synced;

    assign synced  = sync_q[SYNC_STAGES-1];
    assign clean_o = clean_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            run_q   <= '0;
            clean_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            if (synced == clean_q) begin
                run_q <= '0;
            end else if (run_q == CW'(FILTER_LEN - 1)) begin
                clean_q <= synced;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    AST_CLEAN_NEEDS_DWELL: assert property (@(posedge clk) disable iff (rst)
        (clean_q != $past(clean_q)) |-> (synced == clean_q)) else $error("filter"); // R1

endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame #(
    parameter int TIMEOUT_CYC = 12500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       kclk_i,
    input  logic       kdat_i,
    output logic       frm_vld_o,
    output logic [7:0] frm_byte_o
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    logic          kclk_q;
    logic          fall;
    logic [3:0]    bit_idx;
    logic [7:0]    shreg;
    logic          par_q;
    logic [TW-1:0] idle_cnt;

    assign fall = kclk_q & ~kclk_i;

    always_ff @(posedge clk) begin
        frm_vld_o <= 1'b0;
        if (rst) begin
            kclk_q     <= 1'b1;
            bit_idx    <= '0;
            shreg      <= '0;
            par_q      <= 1'b0;
            idle_cnt   <= '0;
            frm_byte_o <= '0;
        end else begin
            kclk_q <= kclk_i;
            if (fall) begin
                idle_cnt <= '0;
                if (bit_idx == 4'd0) begin
                    if (!kdat_i) bit_idx <= 4'd1;
                end else if (bit_idx <= 4'd8) begin
                    shreg   <= {kdat_i, shreg[7:1]};
                    bit_idx <= bit_idx + 4'd1;
                end else if (bit_idx == 4'd9) begin
                    par_q   <= kdat_i;
                    bit_idx <= 4'd10;
                end else begin
                    bit_idx <= 4'd0;
                    if (kdat_i && (^{shreg, par_q})) begin
                        frm_vld_o  <= 1'b1;
                        frm_byte_o <= shreg;
                    end
                end
            end else if (bit_idx != 4'd0) begin
                if (idle_cnt == TW'(TIMEOUT_CYC - 1)) begin
                    bit_idx  <= 4'd0;
                    idle_cnt <= '0;
                end else begin
                    idle_cnt <= idle_cnt + 1'b1;
                end
            end
        end
    end

    AST_FRAME_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        frm_vld_o |-> $past(fall)) else $error("frame"); // R1
    AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frm_vld_o |=> !frm_vld_o) else $error("frame pulse"); // R1

endmodule

// File: rtl/scan_decoder.sv
module scan_decoder
    import kbd_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frm_vld_i,
    input  logic [7:0] frm_byte_i,
    output logic       key_vld_o,
    output logic [6:0] key_code_o
);
    dec_state_t    st;
    ascii_lookup_t lk;

    always_comb lk = scan_lookup(frm_byte_i, st.shift_l | st.shift_r);

    always_ff @(posedge clk) begin
        key_vld_o <= 1'b0;
        if (rst) begin
            st         <= '0;
            key_code_o <= '0;
        end else if (frm_vld_i) begin
            if (frm_byte_i == SC_RELEASE) begin
                st.release_pend <= 1'b1;
            end else if (frm_byte_i == SC_EXTEND) begin
                st.ext_pend <= 1'b1;
            end else if (st.ext_pend) begin
                st.ext_pend     <= 1'b0;
                st.release_pend <= 1'b0;
            end else if (st.release_pend) begin
                st.release_pend <= 1'b0;
                if (frm_byte_i == SC_LSHIFT) st.shift_l <= 1'b0;
                if (frm_byte_i == SC_RSHIFT) st.shift_r <= 1'b0;
            end else if (frm_byte_i == SC_LSHIFT) begin
                st.shift_l <= 1'b1;
            end else if (frm_byte_i == SC_RSHIFT) begin
                st.shift_r <= 1'b1;
            end else if (lk.hit) begin
                key_vld_o  <= 1'b1;
                key_code_o <= lk.code;
            end
        end
    end

    AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (rst)
        (frm_vld_i && (frm_byte_i == SC_RELEASE || frm_byte_i == SC_EXTEND)) |=> !key_vld_o)
        else $error("prefix"); // R7
    AST_RELEASE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (frm_vld_i && st.release_pend) |=> !key_vld_o) else $error("release"); // R7
    AST_EXTEND_SILENT: assert property (@(posedge clk) disable iff (rst)
        (frm_vld_i && st.ext_pend) |=> !key_vld_o) else $error("extend"); // R8
    AST_KEY_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        key_vld_o |-> $past(frm_vld_i)) else $error("spurious key"); // R10

endmodule

// File: rtl/key_port_latch.sv
module key_port_latch (
    input  logic       clk,
    input  logic       rst,
    input  logic       key_vld_i,
    input  logic [6:0] key_code_i,
    input  logic       cs_i,
    input  logic       rd_i,
    output logic [7:0] rdata_o
);
    logic       flag_q;
    logic [6:0] code_q;
    logic       sel;
    logic       sel_q;

    assign sel     = cs_i & rd_i;
    assign rdata_o = {flag_q, code_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            code_q <= '0;
            sel_q  <= 1'b0;
        end else begin
            sel_q <= sel;
            if (key_vld_i) begin
                flag_q <= 1'b1;
                code_q <= key_code_i;
            end else if (sel_q && !sel) begin
                flag_q <= 1'b0;
            end
        end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        key_vld_i |=> rdata_o[7]) else $error("flag set"); // R3
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (sel_q && !sel && !key_vld_i) |=> !rdata_o[7]) else $error("flag clear"); // R4
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !key_vld_i |=> $stable(rdata_o[6:0])) else $error("code hold"); // R4
    AST_NO_SEL_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!sel_q && !key_vld_i) |=> $stable(rdata_o[7])) else $error("unselected"); // R5

endmodule

// File: rtl/kbd_ascii_port.sv
module kbd_ascii_port #(
    parameter int SYNC_STAGES = 2,
    parameter int FILTER_LEN  = 8,
    parameter int TIMEOUT_CYC = 12500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    input  logic       cs_i,
    input  logic       rd_i,
    output logic [7:0] rdata_o
);
    logic       kclk_f;
    logic       kdat_f;
    logic       frm_vld;
    logic [7:0] frm_byte;
    logic       key_vld;
    logic [6:0] key_code;
    logic [1:0] raw_lines;
    logic [1:0] clean_lines;

    assign raw_lines = {ps2_dat_i, ps2_clk_i};
    assign kclk_f    = clean_lines[0];
    assign kdat_f    = clean_lines[1];

    for (genvar g = 0; g < 2; g++) begin : g_line
        ps2_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILTER_LEN(FILTER_LEN)) u_filt (
            .clk(clk), .rst(rst), .raw_i(raw_lines[g]), .clean_o(clean_lines[g]));
    end

    ps2_rx_frame #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
        .clk(clk), .rst(rst), .kclk_i(kclk_f), .kdat_i(kdat_f),
        .frm_vld_o(frm_vld), .frm_byte_o(frm_byte));

    scan_decoder u_dec (
        .clk(clk), .rst(rst), .frm_vld_i(frm_vld), .frm_byte_i(frm_byte),
        .key_vld_o(key_vld), .key_code_o(key_code));

    key_port_latch u_latch (
        .clk(clk), .rst(rst), .key_vld_i(key_vld), .key_code_i(key_code),
        .cs_i(cs_i), .rd_i(rd_i), .rdata_o(rdata_o));

endmodule

// File: tb/tb_kbd_ascii_port.sv
module tb_kbd_ascii_port;
    localparam int HP      = 10;
    localparam int TMO     = 400;
    localparam int SETTLE  = 40;
    localparam int NVEC    = 11;

    // [15:8] scan code, [7] shift held, [6:0] expected ASCII
    localparam logic [15:0] VEC [NVEC] = '{
        16'h1C_41, 16'h32_42, 16'h1A_5A, 16'h45_30, 16'h16_31, 16'h46_39,
        16'h29_20, 16'h5A_0D, 16'h16_A1, 16'h1E_C0, 16'h1C_C1
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       kclk = 1'b1;
    logic       kdat = 1'b1;
    logic       cs = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rdata;
    int         checks = 0;
    int         errors = 0;
    logic [7:0] got;

    always #4 clk = ~clk;

    kbd_ascii_port #(.SYNC_STAGES(2), .FILTER_LEN(4), .TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst(rst), .ps2_clk_i(kclk), .ps2_dat_i(kdat),
        .cs_i(cs), .rd_i(rd), .rdata_o(rdata));

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        wait_cyc(HP);
        kdat = b;
        wait_cyc(HP);
        kclk = 1'b0;
        wait_cyc(HP);
        kclk = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic bad_par, input logic bad_stop);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
        send_bit((~^b) ^ bad_par);
        send_bit(~bad_stop);
        kdat = 1'b1;
        wait_cyc(SETTLE);
    endtask

    task automatic send(input logic [7:0] b);
        send_frame(b, 1'b0, 1'b0);
    endtask

    task automatic read_port(output logic [7:0] v);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1;
        @(negedge clk);
        v = rdata;
        cs = 1'b0; rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        check("R3 reset value", rdata, 8'h00);

        // Table walk: R1 framing, R6 map, R9 shift, R3/R4 flag, R7 release
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][7]) send(8'h12);
            send(VEC[v][15:8]);
            read_port(got);
            check("R3/R6/R9 first read", got, {1'b1, VEC[v][6:0]});
            read_port(got);
            check("R4 second read", got, {1'b0, VEC[v][6:0]});
            send(8'hF0);
            send(VEC[v][15:8]);
            if (VEC[v][7]) begin
                send(8'hF0);
                send(8'h12);
            end
            read_port(got);
            check("R7 release silent", got, {1'b0, VEC[v][6:0]});
        end

        // R9 right shift then release restores unshifted digit
        send(8'h59); send(8'h1E);
        read_port(got);
        check("R9 right shift", got, 8'hC0);
        send(8'hF0); send(8'h59); send(8'h1E);
        read_port(got);
        check("R9 shift released", got, 8'hB2);
        send(8'hF0); send(8'h1E);

        // R2 bad parity and bad stop
        send_frame(8'h1C, 1'b1, 1'b0);
        read_port(got);
        check("R2 bad parity", got, 8'h32);
        send_frame(8'h1C, 1'b0, 1'b1);
        read_port(got);
        check("R2 bad stop", got, 8'h32);

        // R8 extended prefix skips next code
        send(8'hE0); send(8'h1C);
        read_port(got);
        check("R8 extended skipped", got, 8'h32);

        // R10 unmapped code
        send(8'h05);
        read_port(got);
        check("R10 unmapped", got, 8'h32);

        // R5 read strobe without chip select
        send(8'h1C);
        @(negedge clk); rd = 1'b1;
        wait_cyc(3);
        rd = 1'b0;
        wait_cyc(3);
        check("R5 rd alone", rdata, 8'hC1);
        read_port(got);
        check("R5 selected read after", got, 8'hC1);

        // R11 timeout aborts partial frame
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        kdat = 1'b1;
        wait_cyc(TMO + 100);
        send(8'h32);
        read_port(got);
        check("R11 after timeout", got, 8'hC2);

        // R3 flag set again after clear
        send(8'h21);
        check("R3 flag set", rdata, 8'hC3);

        finish_run();
    end
endmodule